// File: doc/BRIEF.md
# Macro-Op / Micro-Op Step Sequencer

This block decides, for every retired step of a simple in-order front end, how the program counters move. It keeps an architectural PC and a next-PC, plus a next-next-PC when the build selects delay-slot mode. It also keeps a micro-PC and a next-micro-PC. An ordinary instruction retires and moves the PC forward by one instruction. A microcoded macro-instruction freezes the architectural PC while the micro-PC walks through its micro-ops one word at a time. When the last micro-op retires, the micro-op state clears and the PC moves on.

Each cycle the decode stage presents two flags: whether the fetched instruction is a macro-op, and whether the operation now executing is its final micro-op. The execute stage presents a retire strobe and a fault flag. A faulting step moves nothing, and the block reports it on a separate output. The current micro-op index is always the micro-PC, so a micro-op ROM outside the block can be indexed by it directly.

Top module: `uop_sequencer`

## Requirements
- R1: A synchronous active-high reset sets `pc` to `RESET_VEC`, `upc` to 0 and `inMacro` to 0.
- R2: A retire of a non-macro step (`inMacro`=0, `decMacro`=0) without fault adds `INSN_BYTES` to `pc` and leaves `upc`=0 and `inMacro`=0, whatever `decLast` is.
- R3: A retire without fault while `inMacro`=0, with `decMacro`=1 and `decLast`=0, sets `inMacro` to 1, sets `upc` to 1 and holds `pc`.
- R4: While `inMacro`=1, a retire without fault and with `decLast`=0 increments `upc` by 1 and holds `pc`; `decMacro` has no effect.
- R5: While `inMacro`=1, a retire without fault and with `decLast`=1 clears `inMacro` and `upc` to 0 and adds `INSN_BYTES` to `pc` in the same cycle.
- R6: A one-micro-op macro-op (`inMacro`=0, `decMacro`=1, `decLast`=1) retired without fault adds `INSN_BYTES` to `pc` and leaves `inMacro`=0 and `upc`=0.
- R7: A retire with `fault`=1 leaves `pc`, `upc` and `inMacro` unchanged, and `faultTaken` is 1 in that same cycle (combinational); `faultTaken` is 0 in every other cycle.
- R8: In a cycle with `retire`=0, `pc`, `upc` and `inMacro` keep their values.
- R9: With `DELAY_SLOT`=1 the visible `pc`, `upc` and `inMacro` sequence is identical to the one without delay slots, and next-PC never equals next-next-PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| decMacro | input | 1 | Decoded instruction is a macro-op (ignored while in a macro-op) |
| decLast | input | 1 | Current operation is the final micro-op of its macro-op |
| fault | input | 1 | The retiring step raised a fault |
| retire | input | 1 | The current step retires this cycle |
| pc | output | PC_W | Architectural program counter |
| upc | output | UPC_W | Micro-PC, equal to the current micro-op index |
| inMacro | output | 1 | A macro-op is in progress |
| faultTaken | output | 1 | Retire with fault in this cycle |

## Verification
A wrong in-macro bit shows up at the first retire after the fault: either `pc` advances while micro-ops should still run, or `upc` restarts at 1 when it should step on. A wrong next-micro-PC is visible at the following non-fault retire, as a `upc` that does not equal the previous value plus one. A wrong next-PC or next-next-PC shows up as a `pc` step other than `INSN_BYTES` at the next architectural advance. A second instance in delay-slot mode is compared cycle by cycle against the same expected values.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // strobes from control to datapath, one retire decision per cycle
  typedef struct packed {
    logic advPc;     // architectural PC moves on
    logic advUpc;    // micro-PC steps
    logic clrUpc;    // micro-op state returns to index 0
    logic firstUop;  // the stepping micro-op is index 0 of a new macro-op
  } seqStrobe_t;
endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       decMacro,
  input  logic       decLast,
  input  logic       fault,
  input  logic       retire,
  output seqStrobe_t st,
  output logic       inMacro,
  output logic       faultTaken
);
  logic inMacroQ;
  logic curIsMacro;
  logic goodRetire;

  // while a macro-op runs, no new decode is taken: decMacro is ignored
  assign curIsMacro = inMacroQ | decMacro;
  assign goodRetire = retire & ~fault;
  assign faultTaken = retire & fault;

  always_comb begin
    st          = '0;
    st.firstUop = ~inMacroQ;
    if (goodRetire) begin
      // the last-micro-op flag wins over the micro-PC step
      st.advPc  = ~curIsMacro | decLast;
      st.clrUpc = curIsMacro & decLast;
      st.advUpc = curIsMacro & ~decLast;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             inMacroQ <= 1'b0;
    else if (goodRetire) inMacroQ <= curIsMacro & ~decLast;
  end

  assign inMacro = inMacroQ;

  assert_macro_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (inMacroQ && goodRetire && decLast) |=> !inMacroQ);
  assert_single_uop_R6: assert property (@(posedge clk) disable iff (rst)
    (!inMacroQ && decMacro && decLast && goodRetire) |=> !inMacroQ);
  assert_fault_keeps_state_R7: assert property (@(posedge clk) disable iff (rst)
    (retire && fault) |=> $stable(inMacroQ));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !retire |=> $stable(inMacroQ));
  assert_macro_enter_R3: assert property (@(posedge clk) disable iff (rst)
    (!inMacroQ && decMacro && !decLast && goodRetire) |=> inMacroQ);
endmodule

// File: rtl/useq_dpath.sv
module useq_dpath
  import useq_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int UPC_W      = 8,
  parameter int INSN_BYTES = 4,
  parameter bit DELAY_SLOT = 1'b0,
  parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       st,
  output logic [PC_W-1:0]  pc,
  output logic [UPC_W-1:0] upc
);
  localparam logic [PC_W-1:0]  STEP    = PC_W'(INSN_BYTES);
  localparam logic [UPC_W-1:0] UPC_ONE = UPC_W'(1);

  logic [PC_W-1:0]  pcQ, npcQ;
  logic [UPC_W-1:0] upcQ, nupcQ, upcBase;

  // a fresh macro-op is already executing index 0, so its step goes to 1
  assign upcBase = st.firstUop ? UPC_ONE : nupcQ;

  always_ff @(posedge clk) begin
    if (rst || st.clrUpc) begin
      upcQ  <= '0;
      nupcQ <= '0;
    end else if (st.advUpc) begin
      upcQ  <= upcBase;
      nupcQ <= upcBase + UPC_ONE;
    end
  end

  generate
    if (DELAY_SLOT) begin : g_delay
      logic [PC_W-1:0] nnpcQ;
      always_ff @(posedge clk) begin
        if (rst) begin
          pcQ   <= RESET_VEC;
          npcQ  <= RESET_VEC + STEP;
          nnpcQ <= RESET_VEC + STEP + STEP;
        end else if (st.advPc) begin
          pcQ   <= npcQ;
          npcQ  <= nnpcQ;
          nnpcQ <= nnpcQ + STEP;
        end
      end
      assert_next_pcs_differ_R9: assert property (@(posedge clk) disable iff (rst)
        npcQ != nnpcQ);
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) begin
          pcQ  <= RESET_VEC;
          npcQ <= RESET_VEC + STEP;
        end else if (st.advPc) begin
          pcQ  <= npcQ;
          npcQ <= npcQ + STEP;
        end
      end
    end
  endgenerate

  assign pc  = pcQ;
  assign upc = upcQ;

  assert_pc_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    !st.advPc |=> $stable(pcQ));
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    st.advPc |=> (pcQ == $past(npcQ)));
  assert_upc_clear_R5: assert property (@(posedge clk) disable iff (rst)
    st.clrUpc |=> (upcQ == '0 && nupcQ == '0));
  assert_nupc_ahead_R4: assert property (@(posedge clk) disable iff (rst)
    (upcQ != '0) |-> (nupcQ == upcQ + UPC_ONE));
endmodule

// File: rtl/uop_sequencer.sv
module uop_sequencer
  import useq_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int UPC_W      = 8,
  parameter int INSN_BYTES = 4,
  parameter bit DELAY_SLOT = 1'b0,
  parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             decMacro,
  input  logic             decLast,
  input  logic             fault,
  input  logic             retire,
  output logic [PC_W-1:0]  pc,
  output logic [UPC_W-1:0] upc,
  output logic             inMacro,
  output logic             faultTaken
);
  seqStrobe_t st;

  useq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .decMacro   (decMacro),
    .decLast    (decLast),
    .fault      (fault),
    .retire     (retire),
    .st         (st),
    .inMacro    (inMacro),
    .faultTaken (faultTaken)
  );

  useq_dpath #(
    .PC_W       (PC_W),
    .UPC_W      (UPC_W),
    .INSN_BYTES (INSN_BYTES),
    .DELAY_SLOT (DELAY_SLOT),
    .RESET_VEC  (RESET_VEC)
  ) u_dpath (
    .clk (clk),
    .rst (rst),
    .st  (st),
    .pc  (pc),
    .upc (upc)
  );
endmodule

// File: tb/uop_sequencer_tb.sv
`timescale 1ns/1ps
module uop_sequencer_tb;
  localparam int PC_W = 32;
  localparam int UPC_W = 8;
  localparam int SZ = 4;
  localparam logic [PC_W-1:0] VEC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic decMacro = 1'b0, decLast = 1'b0, fault = 1'b0, retire = 1'b0;
  logic [PC_W-1:0]  pcA, pcB;
  logic [UPC_W-1:0] upcA, upcB;
  logic inA, inB, ftA, ftB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [PC_W-1:0]  mPc;
  logic [UPC_W-1:0] mUpc;
  logic             mIn;

  always #2.5 clk = ~clk;

  uop_sequencer #(.PC_W(PC_W), .UPC_W(UPC_W), .INSN_BYTES(SZ), .DELAY_SLOT(1'b0),
                  .RESET_VEC(VEC)) u_dut (
    .clk(clk), .rst(rst), .decMacro(decMacro), .decLast(decLast), .fault(fault),
    .retire(retire), .pc(pcA), .upc(upcA), .inMacro(inA), .faultTaken(ftA));

  uop_sequencer #(.PC_W(PC_W), .UPC_W(UPC_W), .INSN_BYTES(SZ), .DELAY_SLOT(1'b1),
                  .RESET_VEC(VEC)) u_dut_ds (
    .clk(clk), .rst(rst), .decMacro(decMacro), .decLast(decLast), .fault(fault),
    .retire(retire), .pc(pcB), .upc(upcB), .inMacro(inB), .faultTaken(ftB));

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string classify(input logic m, input logic l, input logic f,
                                     input logic r);
    if (!r) return "R8";
    if (f) return "R7";
    if (!mIn && !m) return "R2";
    if (!mIn && l) return "R6";
    if (!mIn) return "R3";
    if (l) return "R5";
    return "R4";
  endfunction

  task automatic checkState(input string req);
    chk(req, "pc", 64'(pcA), 64'(mPc));
    chk(req, "upc", 64'(upcA), 64'(mUpc));
    chk(req, "inMacro", 64'(inA), 64'(mIn));
    chk("R9", "pc delay-slot", 64'(pcB), 64'(mPc));
    chk("R9", "upc delay-slot", 64'(upcB), 64'(mUpc));
    chk("R9", "inMacro delay-slot", 64'(inB), 64'(mIn));
  endtask

  // one step: drive at negedge, check faultTaken, clock, check state
  task automatic step(input logic m, input logic l, input logic f, input logic r);
    string tag;
    logic cur;
    @(negedge clk);
    decMacro = m; decLast = l; fault = f; retire = r;
    #1;
    tag = classify(m, l, f, r);
    chk("R7", "faultTaken", 64'(ftA), 64'(r & f));
    chk("R9", "faultTaken delay-slot", 64'(ftB), 64'(r & f));
    cur = mIn | m;
    if (r && !f) begin
      if (!cur) mPc = mPc + SZ;
      else if (l) begin
        mPc = mPc + SZ; mIn = 1'b0; mUpc = '0;
      end else begin
        mUpc = mIn ? mUpc + 1'b1 : UPC_W'(1);
        mIn = 1'b1;
      end
    end
    @(posedge clk);
    #1;
    checkState(tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; retire = 1'b0; fault = 1'b0; decMacro = 1'b0; decLast = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    mPc = VEC; mUpc = '0; mIn = 1'b0;
    checkState("R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    doReset();
    // R2: plain instruction, decLast set but irrelevant
    step(1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    // R3/R4/R5: three micro-op macro, decMacro held high inside (ignored)
    step(1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    // R6: one micro-op macro
    step(1'b1, 1'b1, 1'b0, 1'b1);
    // R7: fault on start, mid-macro and on last micro-op
    step(1'b1, 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    // R8: no retire inside a macro and outside
    step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    // R4: long macro so the micro-PC wraps past its width
    step(1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 300; i++) step(1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 8) == 0,
           ($urandom % 4) != 0);
    end
    // R1: reset in the middle of a macro-op
    step(1'b1, 1'b0, 1'b0, 1'b1);
    doReset();
    step(1'b0, 1'b0, 1'b0, 1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule